// File: doc/BRIEF.md
# Sub-Block Fault Diagnosis and Repair Sequencer

This block takes over once concurrent checking has flagged a fault in a controller. It asks the controller to halt normal operation. It then walks the controller's sub-blocks one at a time, starting from index 0. For each sub-block it clears the signature monitor, taps that sub-block's outputs through the switch-matrix select lines, and lets the controller run one complete program cycle. The monitor's fail flag then decides whether that sub-block is the culprit.

The first sub-block that fails ends the search. The sequencer then isolates that sub-block and hands its function to the spare test logic. It drives an isolate line first and a reroute line one cycle later, and holds both until a new diagnosis is accepted. If every sub-block passes, it reports that no fault was found and touches no repair line. The result is given as a one-cycle done pulse, with a found flag and the faulty index held beside it.

There are two ways to judge the fail flag. In watch mode the flag counts at any cycle of the run. In end-check mode the flag counts only at the cycle that closes the program cycle. There is no data stream here: every pin is a plain control or status level or pulse.

Top module: `subblk_diag_seq`

## Requirements
- R1: After reset, suspend_o, run_o, mon_clr_o, done_o and fault_found_o are 0, and tap_sel_o, iso_o and rrt_o are all zero.
- R2: start_i is accepted only while suspend_o is 0. Acceptance raises suspend_o on the next cycle. No mon_clr_o or run_o appears until halt_ack_i has been seen high.
- R3: Each sub-block gets exactly one mon_clr_o cycle, followed by run_o cycles. During these cycles tap_sel_o is one-hot at the sub-block index, bit k for sub-block k. Indices are visited in ascending order from 0.
- R4: In watch mode (endchk_mode_i = 0 when the start is accepted), mon_fail_i high during any run_o cycle declares the current sub-block faulty. That run ends at once and no further sub-block is tried.
- R5: In end-check mode (endchk_mode_i = 1), mon_fail_i counts only in the cycle where cycle_done_i is high. The run always lasts the full program cycle.
- R6: A sub-block that passes is untapped, and the next index is tried. When sub-block NUM_SUB-1 passes, the run ends with fault_found_o = 0, fault_idx_o = 0, and iso_o and rrt_o left at zero.
- R7: On a fault, iso_o goes one-hot at the faulty index in the cycle after detection. rrt_o follows with the same bit one cycle later. Both hold until the next accepted start clears them.
- R8: done_o is a single-cycle pulse. In that cycle suspend_o is already 0, and fault_found_o and fault_idx_o show the outcome. They hold it until the next done_o.
- R9: start_i and endchk_mode_i are ignored while suspend_o is 1. The mode used is the one sampled when the start was accepted.
- R10: mon_fail_i has no effect outside run_o cycles (while waiting for the halt, or during a monitor clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Diagnosis request, sampled while idle |
| endchk_mode_i | input | 1 | 1: judge fail only at end of program cycle; 0: watch every cycle |
| halt_ack_i | input | 1 | Controller has stopped normal operation |
| cycle_done_i | input | 1 | Last cycle of the current program cycle |
| mon_fail_i | input | 1 | Signature monitor fail flag |
| suspend_o | output | 1 | Request to hold the controller out of normal operation; also busy |
| run_o | output | 1 | Controller runs its program cycle for the tapped sub-block |
| mon_clr_o | output | 1 | One-cycle clear of the signature monitor |
| tap_sel_o | output | NUM_SUB | One-hot switch-matrix tap select |
| iso_o | output | NUM_SUB | One-hot isolate of the faulty sub-block |
| rrt_o | output | NUM_SUB | One-hot reroute of the faulty sub-block through the spare logic |
| done_o | output | 1 | One-cycle end-of-diagnosis pulse |
| fault_found_o | output | 1 | A faulty sub-block was located |
| fault_idx_o | output | IDX_W | Index of the faulty sub-block |

## Verification
The bench models the controller and the monitor around the sequencer. It aims at a fault in the first sub-block, a fault in the last sub-block, and a fault that appears only in the final cycle of a program cycle. A sequencer with an off-by-one on its last index would skip sub-block NUM_SUB-1 or run past it. If it confused the two modes, the run length of the faulty sub-block would be wrong: cut short in end-check mode, or stretched to the full cycle in watch mode. The bench also holds the halt acknowledge low to catch a sequencer that taps before the controller is halted. It sends a second start mid-run to catch a sequencer that restarts or picks up the new mode. It holds a fail flag high outside run cycles to catch a sequencer that blames a sub-block during a monitor clear.

// File: rtl/subblk_diag_pkg.sv
package subblk_diag_pkg;

  typedef enum logic [2:0] {
    DG_IDLE,
    DG_HALT,
    DG_CLEAR,
    DG_RUN,
    DG_ISOLATE,
    DG_REROUTE,
    DG_FINISH
  } dg_state_e;

  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/subblk_onehot.sv
module subblk_onehot #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [W-1:0] idx_i,
  input  logic         en_i,
  output logic [N-1:0] hot_o
);

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign hot_o[g] = en_i && (idx_i == W'(g));
  end

endmodule

// File: rtl/subblk_repair_reg.sv
module subblk_repair_reg #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         iso_set_i,
  input  logic         rrt_set_i,
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] iso_o,
  output logic [N-1:0] rrt_o
);

  logic [N-1:0] hot;
  logic [N-1:0] iso_q;
  logic [N-1:0] rrt_q;

  subblk_onehot #(.N(N), .W(W)) u_sel (
    .idx_i (idx_i),
    .en_i  (1'b1),
    .hot_o (hot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      iso_q <= '0;
      rrt_q <= '0;
    end else begin
      if (iso_set_i) iso_q <= hot;
      if (rrt_set_i) rrt_q <= hot;
    end
  end

  assign iso_o = iso_q;
  assign rrt_o = rrt_q;

endmodule

// File: rtl/subblk_diag_fsm.sv
module subblk_diag_fsm
  import subblk_diag_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         endchk_mode_i,
  input  logic         halt_ack_i,
  input  logic         cycle_done_i,
  input  logic         mon_fail_i,
  output dg_state_e    state_o,
  output logic [W-1:0] idx_o,
  output logic         accept_o,
  output logic         iso_set_o,
  output logic         rrt_set_o,
  output logic         done_o,
  output logic         found_o,
  output logic [W-1:0] fault_idx_o
);

  localparam logic [W-1:0] LAST = W'(N - 1);

  dg_state_e    st_q, st_d;
  logic [W-1:0] idx_q;
  logic         mode_q;
  logic         hit_q;
  logic         done_q;
  logic         found_q;
  logic [W-1:0] fidx_q;
  logic         hit;
  logic         accept;
  logic         iso_set;
  logic         rrt_set;
  logic         advance;

  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    iso_set = 1'b0;
    rrt_set = 1'b0;
    advance = 1'b0;
    hit     = mode_q ? (cycle_done_i & mon_fail_i) : mon_fail_i;
    case (st_q)
      DG_IDLE: begin
        if (start_i) begin
          st_d   = DG_HALT;
          accept = 1'b1;
        end
      end
      DG_HALT:  if (halt_ack_i) st_d = DG_CLEAR;
      DG_CLEAR: st_d = DG_RUN;
      DG_RUN: begin
        if (hit) begin
          st_d    = DG_ISOLATE;
          iso_set = 1'b1;
        end else if (cycle_done_i) begin
          if (idx_q == LAST) begin
            st_d = DG_FINISH;
          end else begin
            st_d    = DG_CLEAR;
            advance = 1'b1;
          end
        end
      end
      DG_ISOLATE: begin
        st_d    = DG_REROUTE;
        rrt_set = 1'b1;
      end
      DG_REROUTE: st_d = DG_FINISH;
      DG_FINISH:  st_d = DG_IDLE;
      default:    st_d = DG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= DG_IDLE;
      idx_q   <= '0;
      mode_q  <= 1'b0;
      hit_q   <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      fidx_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == DG_FINISH);
      if (accept) begin
        idx_q  <= '0;
        mode_q <= endchk_mode_i;
        hit_q  <= 1'b0;
      end
      if (advance) idx_q <= idx_q + W'(1);
      if (iso_set) hit_q <= 1'b1;
      if (st_q == DG_FINISH) begin
        found_q <= hit_q;
        fidx_q  <= hit_q ? idx_q : '0;
      end
    end
  end

  assign state_o     = st_q;
  assign idx_o       = idx_q;
  assign accept_o    = accept;
  assign iso_set_o   = iso_set;
  assign rrt_set_o   = rrt_set;
  assign done_o      = done_q;
  assign found_o     = found_q;
  assign fault_idx_o = fidx_q;

endmodule

// File: rtl/subblk_diag_seq.sv
module subblk_diag_seq
  import subblk_diag_pkg::*;
#(
  parameter  int NUM_SUB = 8,
  localparam int IDX_W   = idx_bits(NUM_SUB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               endchk_mode_i,
  input  logic               halt_ack_i,
  input  logic               cycle_done_i,
  input  logic               mon_fail_i,
  output logic               suspend_o,
  output logic               run_o,
  output logic               mon_clr_o,
  output logic [NUM_SUB-1:0] tap_sel_o,
  output logic [NUM_SUB-1:0] iso_o,
  output logic [NUM_SUB-1:0] rrt_o,
  output logic               done_o,
  output logic               fault_found_o,
  output logic [IDX_W-1:0]   fault_idx_o
);

  dg_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             iso_set;
  logic             rrt_set;
  logic             tap_en;

  subblk_diag_fsm #(.N(NUM_SUB), .W(IDX_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .endchk_mode_i (endchk_mode_i),
    .halt_ack_i    (halt_ack_i),
    .cycle_done_i  (cycle_done_i),
    .mon_fail_i    (mon_fail_i),
    .state_o       (state),
    .idx_o         (idx),
    .accept_o      (accept),
    .iso_set_o     (iso_set),
    .rrt_set_o     (rrt_set),
    .done_o        (done_o),
    .found_o       (fault_found_o),
    .fault_idx_o   (fault_idx_o)
  );

  assign tap_en = (state == DG_CLEAR) || (state == DG_RUN);

  subblk_onehot #(.N(NUM_SUB), .W(IDX_W)) u_tap (
    .idx_i (idx),
    .en_i  (tap_en),
    .hot_o (tap_sel_o)
  );

  subblk_repair_reg #(.N(NUM_SUB), .W(IDX_W)) u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (accept),
    .iso_set_i (iso_set),
    .rrt_set_i (rrt_set),
    .idx_i     (idx),
    .iso_o     (iso_o),
    .rrt_o     (rrt_o)
  );

  assign suspend_o = (state != DG_IDLE);
  assign run_o     = (state == DG_RUN);
  assign mon_clr_o = (state == DG_CLEAR);

endmodule

// File: rtl/subblk_diag_seq_chk.sv
module subblk_diag_seq_chk
  import subblk_diag_pkg::*;
#(
  parameter  int NUM_SUB = 8,
  localparam int IDX_W   = idx_bits(NUM_SUB)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               endchk_mode_i,
  input logic               halt_ack_i,
  input logic               cycle_done_i,
  input logic               mon_fail_i,
  input logic               suspend_o,
  input logic               run_o,
  input logic               mon_clr_o,
  input logic [NUM_SUB-1:0] tap_sel_o,
  input logic [NUM_SUB-1:0] iso_o,
  input logic [NUM_SUB-1:0] rrt_o,
  input logic               done_o,
  input logic               fault_found_o,
  input logic [IDX_W-1:0]   fault_idx_o
);

  logic rrt_any;
  logic iso_any;
  assign rrt_any = |rrt_o;
  assign iso_any = |iso_o;

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tap_sel_o)); // R3
  AST_TAP_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel_o != '0) |-> (run_o || mon_clr_o)); // R3
  AST_CLEAR_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(mon_clr_o)); // R3
  AST_RUN_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o || mon_clr_o) |-> suspend_o); // R2
  AST_ISO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iso_o)); // R7
  AST_REROUTE_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rrt_any) |-> ($past(iso_any) && (rrt_o == iso_o))); // R7
  AST_REPAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend_o && !start_i) |=> ($stable(iso_o) && $stable(rrt_o))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !suspend_o); // R8
  AST_FOUND_HAS_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_found_o) |-> (rrt_any && iso_any)); // R7

endmodule

bind subblk_diag_seq subblk_diag_seq_chk #(.NUM_SUB(NUM_SUB)) u_chk (.*);

// File: tb/subblk_diag_seq_test.sv
`timescale 1ns/1ps
module subblk_diag_seq_test;

  localparam int NSUB = 8;
  localparam int CYC  = 6;
  localparam int NVEC = 8;
  // columns: end-check mode, faulty sub-block (8 = none), first failing run cycle
  localparam int VEC [NVEC][3] = '{
    '{0, 3, 2}, '{1, 3, 2}, '{0, 0, 0}, '{1, 7, 5},
    '{0, 8, 0}, '{1, 8, 0}, '{0, 7, 5}, '{1, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic endchk_mode_i = 1'b0;
  logic halt_ack_i;
  logic cycle_done_i;
  logic mon_fail_i;
  logic suspend_o, run_o, mon_clr_o, done_o, fault_found_o;
  logic [NSUB-1:0] tap_sel_o, iso_o, rrt_o;
  logic [2:0] fault_idx_o;

  logic [3:0] fail_blk = 4'd8;
  logic [7:0] fail_at = 8'd0;
  logic       hold_ack = 1'b0;
  logic       noise = 1'b0;
  logic       cnt_rst = 1'b0;
  logic [7:0] rc;
  logic [7:0] clr_cnt;
  logic       ack1, ack2;
  logic       seen_early;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  subblk_diag_seq #(.NUM_SUB(NSUB)) uut (.*);

  // controller and monitor model
  always @(posedge clk) begin
    if (!rst_n) begin
      rc <= '0; clr_cnt <= '0; ack1 <= 1'b0; ack2 <= 1'b0;
    end else begin
      ack1 <= suspend_o;
      ack2 <= ack1;
      if (mon_clr_o) rc <= '0;
      else if (run_o) rc <= rc + 8'd1;
      if (cnt_rst) clr_cnt <= '0;
      else if (mon_clr_o) clr_cnt <= clr_cnt + 8'd1;
    end
  end
  assign halt_ack_i   = ack2 & ~hold_ack;
  assign cycle_done_i = run_o && (rc == 8'(CYC - 1));
  assign mon_fail_i   = run_o ? (!fail_blk[3] && tap_sel_o[fail_blk[2:0]] && (rc >= fail_at))
                              : noise;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int mode, input int blk, input int at);
    repeat (3) @(negedge clk);
    endchk_mode_i = mode[0];
    fail_blk = 4'(blk);
    fail_at = 8'(at);
    start_i = 1'b1;
    cnt_rst = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt_rst = 1'b0;
    endchk_mode_i = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) chk("watchdog(done)", 0, 1);
  endtask

  task automatic check_result(input string tag, input int mode, input int blk, input int at);
    bit found = (blk < NSUB);
    chk({tag, " R6/R8 found"}, int'(fault_found_o), int'(found));
    chk({tag, " R8 index"}, int'(fault_idx_o), found ? blk : 0);
    chk({tag, " R7 isolate"}, int'(iso_o), found ? (1 << blk) : 0);
    chk({tag, " R7 reroute"}, int'(rrt_o), found ? (1 << blk) : 0);
    chk({tag, " R4/R5 run length"}, int'(rc), (found && mode == 0) ? at + 1 : CYC);
    chk({tag, " R3/R6 sub-blocks tried"}, int'(clr_cnt), found ? blk + 1 : NSUB);
    chk({tag, " R8 suspend released"}, int'(suspend_o), 0);
    @(negedge clk);
    chk({tag, " R8 done single pulse"}, int'(done_o), 0);
  endtask

  initial begin
    #2_000_000;
    chk("watchdog(global)", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 suspend", int'(suspend_o), 0);
    chk("R1 run/clear", int'({run_o, mon_clr_o}), 0);
    chk("R1 tap", int'(tap_sel_o), 0);
    chk("R1 repair", int'({iso_o, rrt_o}), 0);
    chk("R1 done/found", int'({done_o, fault_found_o}), 0);

    for (int i = 0; i < NVEC; i++) begin
      launch(VEC[i][0], VEC[i][1], VEC[i][2]);
      wait_done();
      check_result($sformatf("vec%0d", i), VEC[i][0], VEC[i][1], VEC[i][2]);
    end

    // R2: no tap before the halt acknowledge
    hold_ack = 1'b1;
    launch(0, 2, 1);
    seen_early = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (run_o || mon_clr_o || tap_sel_o != '0) seen_early = 1'b1;
    end
    chk("R2 held before ack", int'(seen_early), 0);
    chk("R2 suspend requested", int'(suspend_o), 1);
    hold_ack = 1'b0;
    wait_done();
    check_result("R2 after ack", 0, 2, 1);

    // R7: repair holds while idle, then clears on a new start
    repeat (5) @(negedge clk);
    chk("R7 isolate held", int'(iso_o), 1 << 2);
    chk("R7 reroute held", int'(rrt_o), 1 << 2);

    // R9: second start mid-run with the other mode is ignored
    launch(0, 5, 1);
    @(negedge clk);
    chk("R7 cleared on start", int'({iso_o, rrt_o}), 0);
    repeat (2) @(negedge clk);
    endchk_mode_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    endchk_mode_i = 1'b0;
    wait_done();
    check_result("R9 busy start", 0, 5, 1);

    // R10: fail flag outside run cycles is ignored
    noise = 1'b1;
    launch(0, 8, 0);
    wait_done();
    check_result("R10 noise", 0, 8, 0);
    noise = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule